// File: doc/BRIEF.md
# I2C Transmit Burst Queue

This block queues outgoing data bytes for an I2C controller and hands them, one at a time, to the bit-level bus engine once the address phase is over. Software pushes bytes by writing a data register; a 64-entry first-in first-out store keeps them in order. A drain sequencer presents each byte to the bus engine and waits for that byte to finish. It then looks at the acknowledge the target returned. When the queue runs dry after an acknowledged byte, a sticky status bit is set and can raise an interrupt.

When the target refuses a byte, the sequencer stops at once. It does not send the bytes still waiting. It flags a refusal status bit and keeps the refusal visible in a control register. The waiting bytes stay where they are until software writes the flush bit. That bit clears itself and also removes the halt. Generating START and STOP conditions and receiving data belong to other blocks.

The register port is a single-cycle write strobe with a 3-bit address, plus a combinational read-data path. The bus side is a valid/done byte handshake: `tx_nak` is sampled in the cycle `tx_done` is high.

Top module: `i2c_txq_writer`

## Requirements
- R1: After reset the queue is empty and disabled, `tx_valid` and `irq` are 0, the status, interrupt-enable and control registers read 0, and the queue-status register (address 4) reads 0x10.
- R2: While the queue is enabled (bit 6 of the queue-control register, address 1), each write to the data register (address 0) stores one byte, and bytes reach `tx_byte` in the order they were written.
- R3: A data-register write while the queue is disabled stores nothing: queue-status bit 4 (empty) stays 1 and `tx_valid` stays 0.
- R4: The queue holds 64 bytes. Queue-status bit 5 reads 1 while it is full. A data write to a full queue is dropped and sets the sticky overflow bit, queue-status bit 0.
- R5: Writing the queue-control register with bit 7 set raises a flush flag, which reads back as bit 7 in the following cycle only. The next edge then empties the queue, clears overflow and releases a refusal halt. Bit 6 of the same write sets the enable.
- R6: When the sequencer is idle and the queue is enabled and not empty, `tx_valid` rises one cycle after a byte is stored. It then holds `tx_byte` steady until `tx_done`, falls in the cycle after `tx_done`, and the next byte follows one cycle later.
- R7: Status bit 1 (address 2) is set when a byte completes with acknowledge and the queue is empty. Interrupt-enable bit 1 (address 3) routes it to `irq`.
- R8: A byte completing with `tx_nak`=1 sets status bit 0 and halts the sequencer. The remaining bytes are kept and not sent until a flush. Interrupt-enable bit 0 routes status bit 0 to `irq`.
- R9: Control-register bit 3 (address 5) shows the acknowledge result of the most recently completed byte: 1 for a refusal, 0 for an acknowledge.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 data, 1 queue control, 2 status, 3 interrupt enable, 4 queue status, 5 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the register at `reg_addr` (combinational) |
| tx_valid | output | 1 | A byte is offered to the bus engine |
| tx_byte | output | 8 | Byte offered to the bus engine |
| tx_done | input | 1 | Bus engine finished the offered byte |
| tx_nak | input | 1 | Target refused that byte (valid with `tx_done`) |
| irq | output | 1 | Interrupt: enabled status bits OR-ed |

## Verification
A data write stored at edge p shows at `tx_valid` after edge p+1. The bench therefore checks for 0 at the first falling edge after the write and for 1 at the next one. Status, control and `tx_valid` results of a `tx_done` appear at the edge that samples `tx_done`. They are read at the falling edge that ends the handshake. A flush is readable as bit 7 right after its write edge and acts one edge later, so the bench reads twice in consecutive half-cycles apart by one clock. All inputs change and all outputs are sampled on falling edges, away from the active edge.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_QCTL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_QSTAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTL   = 3'd5;

  // bit positions software relies on
  localparam int QCTL_FLUSH = 7;
  localparam int QCTL_EN    = 6;
  localparam int ST_EMPTY   = 1;
  localparam int ST_NAK     = 0;
  localparam int QS_FULL    = 5;
  localparam int QS_EMPTY   = 4;
  localparam int QS_OVF     = 0;
  localparam int CTL_NAK    = 3;

  // sticky status update: set wins over write-one-to-clear
  function automatic logic [1:0] stat_next(input logic [1:0] cur,
                                           input logic [1:0] w1c,
                                           input logic [1:0] set);
    return (cur & ~w1c) | set;
  endfunction
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop_req,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c,
                                             input logic pu, input logic po);
    case ({pu, po})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign push  = push_req && !full && !flush;
  assign pop   = pop_req && !empty && !flush;
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= cnt_next(count, push, pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req && !flush) |=> full);
  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/i2cq_drain.sv
module i2cq_drain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         q_en,
  input  logic         q_empty,
  input  logic [W-1:0] q_head,
  output logic         pop,
  output logic         tx_valid,
  output logic [W-1:0] tx_byte,
  input  logic         tx_done,
  input  logic         tx_nak,
  output logic         done_ev,
  output logic         nak_ev,
  output logic         last_nak
);
  logic halted;

  assign pop     = !tx_valid && q_en && !q_empty && !halted && !flush;
  assign done_ev = tx_valid && tx_done;
  assign nak_ev  = done_ev && tx_nak;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      halted   <= 1'b0;
      last_nak <= 1'b0;
    end else begin
      if (pop) begin
        tx_valid <= 1'b1;
        tx_byte  <= q_head;
      end else if (done_ev) begin
        tx_valid <= 1'b0;
      end
      if (done_ev) last_nak <= tx_nak;
      if (flush)       halted <= 1'b0;
      else if (nak_ev) halted <= 1'b1;
    end
  end

  // R6
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_byte)));
  // R8
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !$rose(tx_valid));
endmodule

// File: rtl/i2c_txq_writer.sv
module i2c_txq_writer
  import i2cq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              tx_done,
  input  logic              tx_nak,
  output logic              irq
);
  logic              q_en, flush_q, ovf;
  logic [1:0]        stat, ien;
  logic              wr_data, q_empty, q_full, pop;
  logic              done_ev, nak_ev, last_nak;
  logic [DATA_W-1:0] q_head;
  logic [1:0]        stat_set, stat_clr;

  assign wr_data  = reg_wr && (reg_addr == A_DATA) && q_en;
  assign stat_set = {done_ev && !tx_nak && q_empty, nak_ev};
  assign stat_clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[1:0] : 2'b00;
  assign irq      = |(stat & ien);

  i2cq_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_q),
    .push_req(wr_data), .push_data(reg_wdata),
    .pop_req(pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  i2cq_drain #(.W(DATA_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .flush(flush_q),
    .q_en(q_en), .q_empty(q_empty), .q_head(q_head), .pop(pop),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_done(tx_done), .tx_nak(tx_nak),
    .done_ev(done_ev), .nak_ev(nak_ev), .last_nak(last_nak)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_en    <= 1'b0;
      flush_q <= 1'b0;
      ovf     <= 1'b0;
      stat    <= '0;
      ien     <= '0;
    end else begin
      flush_q <= reg_wr && (reg_addr == A_QCTL) && reg_wdata[QCTL_FLUSH];
      if (reg_wr && reg_addr == A_QCTL) q_en <= reg_wdata[QCTL_EN];
      if (reg_wr && reg_addr == A_IEN)  ien  <= reg_wdata[1:0];
      if (flush_q)                      ovf  <= 1'b0;
      else if (wr_data && q_full)       ovf  <= 1'b1;
      stat <= stat_next(stat, stat_clr, stat_set);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_QCTL: begin
        reg_rdata[QCTL_FLUSH] = flush_q;
        reg_rdata[QCTL_EN]    = q_en;
      end
      A_STAT: reg_rdata[1:0] = stat;
      A_IEN:  reg_rdata[1:0] = ien;
      A_QSTAT: begin
        reg_rdata[QS_FULL]  = q_full;
        reg_rdata[QS_EMPTY] = q_empty;
        reg_rdata[QS_OVF]   = ovf;
      end
      A_CTL:  reg_rdata[CTL_NAK] = last_nak;
      default: reg_rdata = '0;
    endcase
  end

  // R5
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);
  // R7
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && !tx_nak && q_empty) |=> stat[ST_EMPTY]);
  // R8
  nak_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak_ev |=> (stat[ST_NAK] && last_nak));
endmodule

// File: tb/tb_i2c_txq_writer.sv
module tb_i2c_txq_writer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       tx_done = 1'b0;
  logic       tx_nak = 1'b0;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_txq_writer dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // bus engine model: accept one byte, answer ack/nak
  task automatic serve(string req, logic [7:0] exp, logic nak);
    int t = 0;
    while (!tx_valid && t < 300) begin @(negedge clk); t++; end
    check(req, {31'd0, tx_valid}, 32'd1);
    check(req, {24'd0, tx_byte}, {24'd0, exp});
    tx_done = 1'b1; tx_nak = nak;
    @(negedge clk);
    tx_done = 1'b0; tx_nak = 1'b0;
    check("R6 valid drops after done", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 tx_valid", {31'd0, tx_valid}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(3'd4, d); check("R1 qstat", {24'd0, d}, 32'h10);
    rd(3'd2, d); check("R1 stat", {24'd0, d}, 0);
    rd(3'd1, d); check("R1 qctl", {24'd0, d}, 0);
    rd(3'd5, d); check("R1 ctl", {24'd0, d}, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(3'd0, 8'h77);
    idle(3);
    rd(3'd4, d); check("R3 nothing stored", {24'd0, d}, 32'h10);
    check("R3 no transmit", {31'd0, tx_valid}, 0);
    wr(3'd1, 8'h40);
    rd(3'd1, d); check("R5 enable set", {24'd0, d}, 32'h40);
  endtask

  task automatic t_single();
    logic [7:0] d;
    wr(3'd3, 8'h02);
    wr(3'd0, 8'h5A);
    check("R6 not yet valid", {31'd0, tx_valid}, 0);
    @(negedge clk);
    check("R6 valid one cycle later", {31'd0, tx_valid}, 1);
    idle(3);
    check("R6 byte held", {24'd0, tx_byte}, 32'h5A);
    serve("R6 single byte", 8'h5A, 1'b0);
    rd(3'd2, d); check("R7 empty flag", {24'd0, d}, 32'h02);
    check("R7 irq", {31'd0, irq}, 1);
    rd(3'd5, d); check("R9 ack result", {24'd0, d}, 0);
    wr(3'd2, 8'h00);
    rd(3'd2, d); check("R10 write zero keeps", {24'd0, d}, 32'h02);
    wr(3'd2, 8'h02);
    rd(3'd2, d); check("R10 w1c clears", {24'd0, d}, 0);
    check("R10 irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_order();
    logic [7:0] d;
    for (int i = 0; i < 5; i++) wr(3'd0, 8'hA0 + 8'(i));
    for (int i = 0; i < 4; i++) serve("R2 order", 8'hA0 + 8'(i), 1'b0);
    rd(3'd2, d); check("R7 not empty yet", {24'd0, d}, 0);
    // next byte one cycle after the done edge
    @(negedge clk);
    check("R6 next byte follows", {31'd0, tx_valid}, 1);
    serve("R2 order last", 8'hA4, 1'b0);
    rd(3'd2, d); check("R7 empty after last", {24'd0, d}, 32'h02);
    wr(3'd2, 8'h02);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    for (int i = 0; i < 65; i++) wr(3'd0, 8'(i));
    rd(3'd4, d); check("R4 full no overflow", {24'd0, d}, 32'h20);
    wr(3'd0, 8'hEE);
    rd(3'd4, d); check("R4 overflow sticky", {24'd0, d}, 32'h21);
    for (int i = 0; i < 65; i++) serve("R4 drained data", 8'(i), 1'b0);
    idle(3);
    check("R4 dropped byte not sent", {31'd0, tx_valid}, 0);
    rd(3'd4, d); check("R4 overflow kept", {24'd0, d}, 32'h11);
    wr(3'd1, 8'hC0);
    @(negedge clk);
    rd(3'd4, d); check("R5 flush clears overflow", {24'd0, d}, 32'h10);
    wr(3'd2, 8'h03);
  endtask

  task automatic t_nak();
    logic [7:0] d;
    wr(3'd3, 8'h03);
    wr(3'd0, 8'hB1); wr(3'd0, 8'hB2); wr(3'd0, 8'hB3);
    serve("R8 first byte", 8'hB1, 1'b1);
    rd(3'd2, d); check("R8 nak flag", {24'd0, d}, 32'h01);
    check("R8 irq", {31'd0, irq}, 1);
    rd(3'd5, d); check("R9 nak result", {24'd0, d}, 32'h08);
    idle(6);
    check("R8 halted", {31'd0, tx_valid}, 0);
    rd(3'd4, d); check("R8 bytes kept", {24'd0, d}, 0);
    wr(3'd2, 8'h01);
    check("R10 irq cleared", {31'd0, irq}, 0);
    wr(3'd1, 8'hC0);
    rd(3'd1, d); check("R5 flush flag visible", {24'd0, d}, 32'hC0);
    @(negedge clk);
    rd(3'd1, d); check("R5 flush self-clears", {24'd0, d}, 32'h40);
    rd(3'd4, d); check("R5 queue emptied", {24'd0, d}, 32'h10);
    idle(3);
    check("R8 flushed bytes not sent", {31'd0, tx_valid}, 0);
    wr(3'd0, 8'hC4);
    serve("R5 resumes after flush", 8'hC4, 1'b0);
    rd(3'd5, d); check("R9 ack clears", {24'd0, d}, 0);
    rd(3'd2, d); check("R7 empty after resume", {24'd0, d}, 32'h02);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_single();
    t_order();
    t_overflow();
    t_nak();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule